// File: doc/BRIEF.md
# Phase-Aligned Gated Clock Burst Generator

This block turns one fast clock into periodic bursts of a slower clock. A prescaler divides the fast clock by a fixed ratio, eight by default, to make the divided clock. A period counter runs from the same fast clock and builds an enable gate. The gate's start and end points are set in single fast-clock ticks, so the gate edges can move in steps of one eighth of a divided-clock cycle. This lets delays on the board be trimmed out. The burst output is the divided clock, passed only while the gate is open, in the same way as an output-enabled clock buffer. The default settings give a 272-tick period (one burst every 34 divided-clock cycles) with the gate open for 128 ticks (16 divided-clock cycles).

A free-running counter has no known phase against outside logic. To fix this, the block watches an external reference input. Software-side logic pulses `arm`. The next qualifying edge on the reference then clears the prescaler and the period counter together. The edge that qualifies is rising or falling, as chosen by `edge_sel`. After that the block runs freely. The period and the two gate offsets are copied into internal registers only at a period wrap or at alignment. A new setting therefore cannot produce a partial gate.

Top module: `burst_gate_gen`

## Requirements
- R1: After alignment, `div_clk` has a period of DIV fast ticks. It is high for the first DIV/2 ticks of each cycle and low for the rest. The first sample after alignment (phase 0) is high.
- R2: `gate` is high exactly when (phase modulo period) lies in the range [on offset, off offset). The phase counts fast ticks since alignment. The setting needs period >= 2 and on < off <= period. Moving either offset by one changes the gate by one fast tick.
- R3: `ref_in` may change between two rising edges of `clk`. If that change is the qualifying edge, the outputs sampled after the fourth following rising edge show phase 0.
- R4: `edge_sel` = 0 selects a rising reference edge and `edge_sel` = 1 selects a falling one. An edge of the other polarity aligns nothing and leaves `aligned` low.
- R5: Only the first qualifying edge after an `arm` pulse aligns. Later reference edges of either polarity leave the phase of all outputs unchanged until the next `arm`.
- R6: Values on `period_cfg`, `on_cfg` and `off_cfg` take effect only from the next period wrap or alignment. A period already under way completes with its old settings.
- R7: `burst_clk` is high only while `div_clk` is high. For each divided-clock cycle it carries the whole high half or nothing, based on the gate value at the last tick before `div_clk` rises. That is, burst(p) = div(p) AND gate(p - p mod DIV - 1) for p >= DIV.
- R8: `aligned` goes high on alignment. It is cleared by reset or by an `arm` pulse, and it is low on the sample right after that pulse.
- R9: While `rst` is high, `div_clk`, `gate`, `burst_clk` and `aligned` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse that arms alignment on the next qualifying reference edge |
| ref_in | input | 1 | Asynchronous phase reference |
| edge_sel | input | 1 | 0 = rising reference edge, 1 = falling |
| period_cfg | input | CNT_W | Gate period in fast ticks |
| on_cfg | input | CNT_W | Phase at which the gate opens |
| off_cfg | input | CNT_W | Phase at which the gate closes |
| div_clk | output | 1 | Divided clock |
| gate | output | 1 | Burst enable gate |
| burst_clk | output | 1 | Divided clock passed while the gate is open |
| aligned | output | 1 | High once alignment has occurred since the last arm or reset |

## Verification
Each run uses both edge polarities. It first applies a reference edge of the wrong polarity, which shows that the edge selector is honoured. Then the right edge comes, and every later sample is checked against a phase count that starts at that edge. Any error in the synchronizer latency shows up as a constant phase offset. Directed settings cover the plain 272/0/128 case, offsets of one tick, and a gate that ends exactly at the period boundary. Randomly drawn periods and offsets are changed halfway through the first period, which separates a setting applied at once from one applied at the wrap. Extra reference edges after alignment confirm that a disarmed block keeps its phase.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  function automatic int half_of(input int d);
    return d / 2;
  endfunction
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic edge_sel,
  output logic hit
);
  import burst_gate_pkg::*;

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], ref_in};
  end

  always_comb begin
    if (edge_kind_e'(edge_sel) == EDGE_FALL) hit = ~sh[STAGES-1] &  sh[STAGES];
    else                                     hit =  sh[STAGES-1] & ~sh[STAGES];
  end
endmodule

// File: rtl/phase_prescaler.sv
module phase_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic div_next
);
  import burst_gate_pkg::*;

  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = half_of(DIV);

  logic [PW-1:0] pre;

  generate
    if ((1 << PW) == DIV) begin : g_pow2
      always_ff @(posedge clk) begin
        if (rst || clear) pre <= '0;
        else              pre <= pre + 1'b1;
      end
    end else begin : g_mod
      always_ff @(posedge clk) begin
        if (rst || clear)              pre <= '0;
        else if (pre == PW'(DIV - 1))  pre <= '0;
        else                           pre <= pre + 1'b1;
      end
    end
  endgenerate

  assign div_next = (pre < PW'(HALF));
endmodule

// File: rtl/period_gate_timer.sv
module period_gate_timer #(
  parameter int CNT_W      = 12,
  parameter int RST_PERIOD = 272,
  parameter int RST_ON     = 0,
  parameter int RST_OFF    = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [CNT_W-1:0] on_cfg,
  input  logic [CNT_W-1:0] off_cfg,
  output logic             gate_next
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_sh, on_sh, off_sh;
  logic             wrap;

  assign wrap = (cnt == per_sh - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      per_sh <= CNT_W'(RST_PERIOD);
      on_sh  <= CNT_W'(RST_ON);
      off_sh <= CNT_W'(RST_OFF);
    end else if (clear || wrap) begin
      cnt    <= '0;
      per_sh <= period_cfg;
      on_sh  <= on_cfg;
      off_sh <= off_cfg;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  assign gate_next = (cnt >= on_sh) && (cnt < off_sh);
endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic div_next,
  input  logic gate_next,
  output logic div_clk,
  output logic gate,
  output logic burst_clk
);
  logic en;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_clk   <= 1'b0;
      gate      <= 1'b0;
      burst_clk <= 1'b0;
      en        <= 1'b0;
    end else begin
      div_clk   <= div_next;
      gate      <= gate_next;
      if (!div_next) en <= gate_next;
      burst_clk <= div_next & en;
    end
  end
endmodule

// File: rtl/burst_gate_gen.sv
module burst_gate_gen #(
  parameter int DIV         = 8,
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int RST_PERIOD  = 272,
  parameter int RST_ON      = 0,
  parameter int RST_OFF     = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             ref_in,
  input  logic             edge_sel,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [CNT_W-1:0] on_cfg,
  input  logic [CNT_W-1:0] off_cfg,
  output logic             div_clk,
  output logic             gate,
  output logic             burst_clk,
  output logic             aligned
);
  logic hit, armed, align, div_next, gate_next;

  ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ref_in(ref_in), .edge_sel(edge_sel), .hit(hit)
  );

  assign align = armed & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      aligned <= 1'b0;
    end else if (arm) begin
      armed   <= 1'b1;
      aligned <= 1'b0;
    end else if (align) begin
      armed   <= 1'b0;
      aligned <= 1'b1;
    end
  end

  phase_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .clear(align), .div_next(div_next)
  );

  period_gate_timer #(
    .CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD), .RST_ON(RST_ON), .RST_OFF(RST_OFF)
  ) u_timer (
    .clk(clk), .rst(rst), .clear(align),
    .period_cfg(period_cfg), .on_cfg(on_cfg), .off_cfg(off_cfg),
    .gate_next(gate_next)
  );

  burst_out_stage u_out (
    .clk(clk), .rst(rst), .div_next(div_next), .gate_next(gate_next),
    .div_clk(div_clk), .gate(gate), .burst_clk(burst_clk)
  );
endmodule

// File: rtl/burst_gate_chk.sv
module burst_gate_chk (
  input logic clk,
  input logic rst,
  input logic arm,
  input logic div_clk,
  input logic burst_clk,
  input logic aligned
);
  p_burst_within_div_r7: assert property (@(posedge clk) disable iff (rst)
    burst_clk |-> div_clk);

  p_burst_full_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_clk) |-> $rose(div_clk));

  p_burst_full_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(burst_clk) |-> $fell(div_clk));

  p_arm_clears_r8: assert property (@(posedge clk) disable iff (rst)
    arm |=> !aligned);

  p_phase_zero_high_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |=> div_clk);
endmodule

bind burst_gate_gen burst_gate_chk u_chk (
  .clk(clk), .rst(rst), .arm(arm), .div_clk(div_clk),
  .burst_clk(burst_clk), .aligned(aligned)
);

// File: tb/burst_gate_gen_bench.sv
`timescale 1ns/1ps
module burst_gate_gen_bench;
  localparam int DIV = 8;
  localparam int CW  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0, ref_in = 1'b0, edge_sel = 1'b0;
  logic [CW-1:0] period_cfg = CW'(272), on_cfg = '0, off_cfg = CW'(128);
  logic div_clk, gate, burst_clk, aligned;

  int errors = 0;
  int checks = 0;
  int P0, ON0, OFF0, P1, ON1, OFF1;

  always #2 clk = ~clk;

  burst_gate_gen #(.DIV(DIV), .CNT_W(CW)) u_burst_gate_gen (
    .clk(clk), .rst(rst), .arm(arm), .ref_in(ref_in), .edge_sel(edge_sel),
    .period_cfg(period_cfg), .on_cfg(on_cfg), .off_cfg(off_cfg),
    .div_clk(div_clk), .gate(gate), .burst_clk(burst_clk), .aligned(aligned)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic bit div_at(input int p);
    return (p % DIV) < (DIV / 2);
  endfunction

  function automatic bit gate_at(input int p);
    int q;
    if (p < P0) return (p >= ON0) && (p < OFF0);
    q = (p - P0) % P1;
    return (q >= ON1) && (q < OFF1);
  endfunction

  task automatic run_case(input bit sel, input int p0, input int on0, input int off0,
                          input int p1, input int on1, input int off1);
    P0 = p0; ON0 = on0; OFF0 = off0; P1 = p1; ON1 = on1; OFF1 = off1;
    @(negedge clk);
    edge_sel   = sel;
    ref_in     = ~sel;          // level after a selected edge
    period_cfg = CW'(p0); on_cfg = CW'(on0); off_cfg = CW'(off0);
    repeat (6) @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    chk(aligned == 1'b0, "R8 aligned cleared by arm", aligned, 0);
    ref_in = ~ref_in;           // non-selected edge
    repeat (6) @(negedge clk);
    chk(aligned == 1'b0, "R4 wrong polarity edge ignored", aligned, 0);
    ref_in = ~ref_in;           // selected edge
    repeat (4) @(posedge clk);
    for (int p = 0; p < p0 + 2 * p1 + 16; p++) begin
      @(negedge clk);
      if (p == 0) begin
        chk(aligned == 1'b1, "R8 aligned after edge", aligned, 1);
        chk(div_clk == 1'b1, "R3 phase zero high", div_clk, 1);
      end
      chk(div_clk == div_at(p), $sformatf("R1 div phase %0d", p), div_clk, div_at(p));
      chk(gate == gate_at(p), $sformatf("R2 R6 gate phase %0d", p), gate, gate_at(p));
      if (p >= DIV || (p % DIV) >= DIV / 2) begin
        bit exp_b;
        exp_b = div_at(p) && ((p % DIV) >= DIV / 2 ? 1'b0 : gate_at(p - (p % DIV) - 1));
        chk(burst_clk == exp_b, $sformatf("R7 burst phase %0d", p), burst_clk, exp_b);
      end
      if (p == p0 / 2) begin
        period_cfg = CW'(p1); on_cfg = CW'(on1); off_cfg = CW'(off1);
      end
      if (p == 20 || p == 30) ref_in = ~ref_in;   // R5: edges after alignment
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(div_clk == 0 && gate == 0 && burst_clk == 0 && aligned == 0,
        "R9 reset outputs", {div_clk, gate, burst_clk, aligned}, 0);
    rst = 1'b0;
    run_case(1'b0, 272, 0, 128, 272, 0, 128);
    run_case(1'b1, 272, 3, 131, 272, 4, 132);
    run_case(1'b0, 16, 15, 16, 24, 0, 24);
    run_case(1'b1, 40, 1, 2, 17, 9, 10);
    for (int k = 0; k < 6; k++) begin
      int a, b, c, d, e, f;
      a = 16 + int'($urandom % 285);
      b = int'($urandom % (a - 1));
      c = b + 1 + int'($urandom % (a - b));
      d = 16 + int'($urandom % 285);
      e = int'($urandom % (d - 1));
      f = e + 1 + int'($urandom % (d - e));
      run_case(1'($urandom % 2), a, b, c, d, e, f);
    end
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end
endmodule